// File: doc/BRIEF.md
# Indirect Interrupt-Line Configuration Window

This block gives several requesting domains a small register window through which they configure a bank of wired interrupt lines. A domain cannot address a line directly. It first stores an interrupt ID in its own private select register. It then reads or writes that line's trigger mode through a configuration register, and the line's owning domain through a domain register. A status register tells the domain whether its current selection may be used. It also reports that no update is pending.

Every request carries the requester's domain code, and selections belong to one domain only. A line can be reached by the domain that owns it and by the most privileged domain, code 3. Only domain 3 can see or change who owns a line. Writes take effect at the clock edge that accepts them. A read returns its data one cycle after the request.

The response path is a two-state machine. In READY, no read data is pending. In REPLY, the read data captured at the previous edge is presented. READY moves to REPLY on an accepted read (transition "read accepted"). REPLY stays in REPLY on a back-to-back read ("read chained") and returns to READY otherwise ("reply done"). A write, or no request, in READY keeps READY ("stay ready").

Top module: `irq_line_cfg_win`

## Requirements
- R1: Offset 0x0 is the select register. A write there stores bits [23:0] of the write data as the ID for the requesting domain only, and changes no line state. Each of the four domains (codes 0..3) keeps its own ID.
- R2: A selection is usable when its ID lies in [BASE_ID, BASE_ID+NUM_LINES) and either the requester is domain 3 or the selected line's owner equals the requester.
- R3: A read of offset 0x4 (status) returns bit 1 = 1 exactly when the requester's selection is usable.
- R4: Status bit 0 (idle) always reads 1. All other status bits read 0.
- R5: Offset 0x8 holds the selected line's trigger mode in bit 0 (0 = level, 1 = edge). With a usable selection, it reads and writes that bit. Otherwise it reads 0 and a write changes nothing.
- R6: Offset 0xC holds the selected line's owner in bits [1:0]. It is readable and writable only by domain 3 with a usable selection. Any other requester reads 0 and its writes have no effect.
- R7: After reset, every domain's ID is BASE_ID+NUM_LINES, so status reads 0x1. Every line has trigger mode 0 and is owned by DEF_OWNER.
- R8: A read of offset 0x0 returns 0, so the select register cannot be read back. A read of any unmapped offset returns 0. A write to any unmapped offset changes nothing.
- R9: A read request accepted at one edge gives rsp_valid = 1 with its data during the next cycle. rsp_valid is 0 in a cycle that follows no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dom | input | 2 | Requesting domain code (3 = most privileged) |
| req_addr | input | 4 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume that at most one request arrives per cycle and that req_dom, req_addr and req_write are stable while req_valid is high. They also assume the domain code always names one of the four implemented domains. The bench drives each request for exactly one clock, from the falling edge, with domain codes 0 to 3 only. It leaves a gap between requests and samples each response at the falling edge that follows its reply cycle.

// File: rtl/irq_cfg_pkg.sv
package irq_cfg_pkg;
    localparam int ID_W   = 24;
    localparam int DATA_W = 32;
    localparam int AW     = 4;

    localparam logic [AW-1:0] OFS_SEL  = 4'h0;
    localparam logic [AW-1:0] OFS_STAT = 4'h4;
    localparam logic [AW-1:0] OFS_CFG  = 4'h8;
    localparam logic [AW-1:0] OFS_DOM  = 4'hC;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_REPLY = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/irq_cfg_selbank.sv
module irq_cfg_selbank
    import irq_cfg_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int DOM_W = 2,
    parameter logic [ID_W-1:0] RST_ID = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [DOM_W-1:0]              wr_dom,
    input  logic [ID_W-1:0]               wr_id,
    output logic [NUM_DOM-1:0][ID_W-1:0]  sel_id
);
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_id[d] <= RST_ID;
            end else if (wr_en && (wr_dom == DOM_W'(d))) begin
                sel_id[d] <= wr_id;
            end
        end
    end
endmodule

// File: rtl/irq_cfg_lookup.sv
module irq_cfg_lookup
    import irq_cfg_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int DOM_W = 2,
    parameter int NUM_LINES = 64,
    parameter int IDX_W = 6,
    parameter logic [ID_W-1:0] BASE_ID = '0
) (
    input  logic [DOM_W-1:0]                 req_dom,
    input  logic [NUM_DOM-1:0][ID_W-1:0]     sel_id,
    input  logic [NUM_LINES-1:0][DOM_W-1:0]  own_vec,
    output logic                             sel_ok,
    output logic [IDX_W-1:0]                 sel_idx
);
    localparam logic [ID_W:0] LO = {1'b0, BASE_ID};
    localparam logic [ID_W:0] HI = LO + (ID_W+1)'(NUM_LINES);
    localparam logic [DOM_W-1:0] TOP_DOM = DOM_W'(NUM_DOM - 1);

    logic [ID_W-1:0] id;
    logic [ID_W:0]   id_ext;
    logic [ID_W:0]   offs;
    logic            in_range;

    always_comb begin
        id       = sel_id[req_dom];
        id_ext   = {1'b0, id};
        offs     = id_ext - LO;
        in_range = (id_ext >= LO) && (id_ext < HI);
        sel_idx  = offs[IDX_W-1:0];
        sel_ok   = in_range && ((req_dom == TOP_DOM) || (own_vec[sel_idx] == req_dom));
    end
endmodule

// File: rtl/irq_cfg_linestore.sv
module irq_cfg_linestore
    import irq_cfg_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int IDX_W = 6,
    parameter int DOM_W = 2,
    parameter logic [DOM_W-1:0] DEF_OWNER = '0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tm_we,
    input  logic                             own_we,
    input  logic [IDX_W-1:0]                 idx,
    input  logic                             tm_in,
    input  logic [DOM_W-1:0]                 own_in,
    output logic [NUM_LINES-1:0]             tm_vec,
    output logic [NUM_LINES-1:0][DOM_W-1:0]  own_vec
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tm_vec[i]  <= 1'b0;
                own_vec[i] <= DEF_OWNER;
            end else begin
                if (tm_we && (idx == IDX_W'(i))) tm_vec[i] <= tm_in;
                if (own_we && (idx == IDX_W'(i))) own_vec[i] <= own_in;
            end
        end
    end
endmodule

// File: rtl/irq_line_cfg_win.sv
module irq_line_cfg_win
    import irq_cfg_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int NUM_LINES = 64,
    parameter logic [ID_W-1:0] BASE_ID = 24'd32,
    parameter logic [1:0] DEF_OWNER = 2'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_dom,
    input  logic [3:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);
    localparam int DOM_W = 2;
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam logic [ID_W-1:0] RST_ID = BASE_ID + ID_W'(NUM_LINES);
    localparam logic [DOM_W-1:0] TOP_DOM = DOM_W'(NUM_DOM - 1);

    logic [NUM_DOM-1:0][ID_W-1:0]    sel_id;
    logic [NUM_LINES-1:0]            tm_vec;
    logic [NUM_LINES-1:0][DOM_W-1:0] own_vec;
    logic                            sel_ok;
    logic [IDX_W-1:0]                sel_idx;
    logic                            wr_sel, wr_tm, wr_own, rd_req;
    logic [DATA_W-1:0]               rd_mux, rdata_q;
    rsp_state_e                      state_q, state_d;

    assign rd_req = req_valid && !req_write;
    assign wr_sel = req_valid && req_write && (req_addr == OFS_SEL);
    assign wr_tm  = req_valid && req_write && (req_addr == OFS_CFG) && sel_ok;
    assign wr_own = req_valid && req_write && (req_addr == OFS_DOM)
                    && (req_dom == TOP_DOM) && sel_ok;

    irq_cfg_selbank #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W), .RST_ID(RST_ID)) u_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel), .wr_dom(req_dom),
        .wr_id(req_wdata[ID_W-1:0]), .sel_id(sel_id)
    );

    irq_cfg_lookup #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W), .NUM_LINES(NUM_LINES),
                     .IDX_W(IDX_W), .BASE_ID(BASE_ID)) u_look (
        .req_dom(req_dom), .sel_id(sel_id), .own_vec(own_vec),
        .sel_ok(sel_ok), .sel_idx(sel_idx)
    );

    irq_cfg_linestore #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .DOM_W(DOM_W),
                        .DEF_OWNER(DEF_OWNER)) u_lines (
        .clk(clk), .rst_n(rst_n), .tm_we(wr_tm), .own_we(wr_own), .idx(sel_idx),
        .tm_in(req_wdata[0]), .own_in(req_wdata[DOM_W-1:0]),
        .tm_vec(tm_vec), .own_vec(own_vec)
    );

    // Read data selection
    always_comb begin
        rd_mux = '0;
        unique case (req_addr)
            OFS_STAT: rd_mux = {{(DATA_W-2){1'b0}}, sel_ok, 1'b1};
            OFS_CFG:  rd_mux = {{(DATA_W-1){1'b0}}, sel_ok && tm_vec[sel_idx]};
            OFS_DOM:  if (sel_ok && (req_dom == TOP_DOM))
                          rd_mux = {{(DATA_W-DOM_W){1'b0}}, own_vec[sel_idx]};
            default:  rd_mux = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (rd_req) state_d = ST_REPLY;
            ST_REPLY: state_d = rd_req ? ST_REPLY : ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_mux;
    end

    // Outputs
    always_comb begin
        rsp_valid = (state_q == ST_REPLY);
        rsp_rdata = rsp_valid ? rdata_q : '0;
    end

    a_r9_read_reply: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);
    a_r8_sel_raz: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == OFS_SEL) |=> (rsp_rdata == 32'd0));
    a_r6_dom_raz: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == OFS_DOM && req_dom != TOP_DOM) |=> (rsp_rdata == 32'd0));
    a_r4_idle_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr == OFS_STAT) |=> (rsp_rdata[0] && rsp_rdata[31:2] == 30'd0));
    a_r5_drop_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFS_CFG && !sel_ok) |=> $stable(tm_vec));
    a_r6_dom_wi: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_dom != TOP_DOM) |=> $stable(own_vec));
    a_r1_sel_no_line: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == OFS_SEL) |=> ($stable(tm_vec) && $stable(own_vec)));
endmodule

// File: tb/tb_irq_line_cfg_win.sv
module tb_irq_line_cfg_win;
    localparam int B = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_dom = '0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_line_cfg_win #(.NUM_DOM(4), .NUM_LINES(64), .BASE_ID(24'd32), .DEF_OWNER(2'd1)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_dom(req_dom), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] d, input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_dom = d; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] d, input logic [3:0] a, input logic [31:0] exp,
                      input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_dom = d; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        chk(req, rsp_rdata, exp);
        @(negedge clk);
        chk({req, " R9 valid drops"}, {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset;
        for (int d = 0; d < 4; d++) rd(2'(d), 4'h4, 32'h1, "R7 reset status");
        wr(2'd3, 4'h0, B + 63);
        rd(2'd3, 4'h8, 32'h0, "R7 reset tm");
        rd(2'd3, 4'hC, 32'h1, "R7 reset owner");
    endtask

    task automatic t_owner_access;
        wr(2'd1, 4'h0, B + 5);
        rd(2'd1, 4'h4, 32'h3, "R3 owner valid");
        wr(2'd1, 4'h8, 32'h1);
        rd(2'd1, 4'h8, 32'h1, "R5 tm write");
        wr(2'd0, 4'h0, B + 5);
        rd(2'd0, 4'h4, 32'h1, "R2 non-owner invalid");
        wr(2'd0, 4'h8, 32'h0);
        rd(2'd0, 4'h8, 32'h0, "R5 invalid reads 0");
        rd(2'd1, 4'h8, 32'h1, "R5 dropped write");
        rd(2'd1, 4'h4, 32'h3, "R1 private select");
    endtask

    task automatic t_range;
        wr(2'd1, 4'h0, B + 64);
        rd(2'd1, 4'h4, 32'h1, "R2 above range");
        wr(2'd1, 4'h0, B - 1);
        rd(2'd1, 4'h4, 32'h1, "R2 below range");
        wr(2'd1, 4'h0, B + 63);
        rd(2'd1, 4'h4, 32'h3, "R2 last line");
        wr(2'd1, 4'h0, 32'hFF00_0000 | (B + 5));
        rd(2'd1, 4'h4, 32'h3, "R1 upper bits dropped");
    endtask

    task automatic t_domain_reg;
        wr(2'd3, 4'h0, B + 5);
        rd(2'd3, 4'h4, 32'h3, "R2 top domain valid");
        rd(2'd3, 4'hC, 32'h1, "R6 owner read");
        wr(2'd1, 4'hC, 32'h0);
        rd(2'd1, 4'hC, 32'h0, "R6 non-top reads 0");
        rd(2'd3, 4'hC, 32'h1, "R6 non-top write ignored");
        wr(2'd3, 4'hC, 32'h2);
        rd(2'd3, 4'hC, 32'h2, "R6 owner write");
        rd(2'd1, 4'h4, 32'h1, "R2 old owner loses");
        wr(2'd2, 4'h0, B + 5);
        rd(2'd2, 4'h4, 32'h3, "R2 new owner valid");
        rd(2'd2, 4'h8, 32'h1, "R5 new owner reads tm");
    endtask

    task automatic t_unmapped;
        rd(2'd2, 4'h0, 32'h0, "R8 select raz");
        rd(2'd2, 4'h1, 32'h0, "R8 unmapped raz");
        wr(2'd2, 4'h9, 32'h0);
        wr(2'd2, 4'hD, 32'h0);
        rd(2'd2, 4'h8, 32'h1, "R8 unmapped write ignored tm");
        rd(2'd3, 4'hC, 32'h2, "R8 unmapped write ignored owner");
        rd(2'd2, 4'h4, 32'h3, "R4 status idle");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_dom = 2'd2; req_addr = 4'h4;
        @(negedge clk);
        chk("R9 first reply", {rsp_valid, rsp_rdata[30:0]}, {1'b1, 31'h3});
        req_addr = 4'h8;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 chained reply", {rsp_valid, rsp_rdata[30:0]}, {1'b1, 31'h1});
        @(negedge clk);
        chk("R9 idle after chain", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset no reply", {31'd0, rsp_valid}, 32'd0);
        t_reset();
        t_owner_access();
        t_range();
        t_domain_reg();
        t_unmapped();
        t_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule